// File: doc/BRIEF.md
# Byte-Serial Recirculating Shift Memory

A byte-wide serial store built from nine shift channels that all move together. Every channel holds 1024 bits. Each channel is a chain of 128-bit segments, and a regenerating refresh stage closes each segment. A word written into the head of the chain comes back to the tail exactly one full period later, which is 1024 bit cycles. Access is therefore in block order: the host reaches a word by waiting for it to come round.

One bit cycle is one pulse on the first phase input and then one pulse on the second. Both are enables sampled on the system clock, and they must not be high together. The first phase clears the output drive, latches the mode inputs and moves the stored data by half a bit. The second phase completes the move, senses the tail byte and puts it on the shared bus. In the same step it loads the head stage either from the tail (recirculation) or from the bus (writing). The mode comes from two active-low strobes, one for read and one for write, and a data-enable input. With data-enable low, the strobes have no effect and the block only recirculates. The bus is three-state, so several blocks can share it. A position counter reports which word is at the tail.

Top module: `bsm_shift_memory`

## Requirements
- R1: A byte stored while the position output reads a value a is sensed unchanged, on all nine bits, when the position next reads a, which is 1024 bit cycles later. This holds for every a in 0..1023 and survives all segment boundaries.
- R2: The position output is 0 after reset. It rises by one on every second-phase pulse, wraps from 1023 to 0, and does not move on a first-phase pulse or on a clock with neither phase.
- R3: Read mode is data-enable 1, read strobe 0 and write strobe 1. From the clock after the second phase, the bus carries the byte stored at the current position. The stored contents are left unchanged.
- R4: Write mode is data-enable 1, read strobe 1 and write strobe 0. The byte on the bus at the second-phase edge is stored at the current position. The block does not drive the bus.
- R5: Read-modify-write has both strobes at 0 and data-enable at 1. The bus value at the second-phase edge is stored. After that edge the block drives the old byte held at that position.
- R6: With data-enable 0, both strobes are ignored. The bus stays undriven and the contents only recirculate.
- R7: The mode is the one latched at the first-phase pulse. A change of the strobes between the first and second phase has no effect on that bit cycle.
- R8: The bus drive begins after a second-phase pulse in a reading mode and is released at the next first-phase pulse.
- R9: Clocks with neither phase high (a stretched, low-duty standby) change neither the contents nor the position.
- R10: After reset the position is 0 and the bus is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which both phase enables are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph1 | input | 1 | First-phase enable: latch mode, release bus, half shift |
| ph2 | input | 1 | Second-phase enable: finish shift, sense tail, load head |
| read_n | input | 1 | Active-low read strobe |
| write_n | input | 1 | Active-low write strobe |
| den | input | 1 | Data enable; low forces recirculation and a released bus |
| data | inout | 9 | Three-state bidirectional byte bus |
| pos | output | 10 | Index of the word currently at the tail |

## Verification
On every clock, the assertions check the following: the two phases never overlap; the position advances only on the second phase and wraps correctly; the refresh stages and the segment pointers move only on the second phase; the bus drive is released by the first phase and starts only after a second phase; and a low data-enable latches recirculation. The bench scenarios show what no single-cycle property can: a full 1024-cycle retention through every segment; read, write and read-modify-write giving the right bytes at the right positions; strobe changes after the mode latch having no effect; and disabled or idle periods leaving the contents intact.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

   // bit 0: tail byte goes to the bus, bit 1: head stage loads from the bus
   typedef enum logic [1:0] {
      MODE_RECIRC = 2'b00,
      MODE_READ   = 2'b01,
      MODE_WRITE  = 2'b10,
      MODE_RMW    = 2'b11
   } bsm_mode_e;

   function automatic logic mode_reads(input bsm_mode_e m);
      return m[0];
   endfunction

   function automatic logic mode_writes(input bsm_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
   import bsm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ph1,
   input  logic      ph2,
   input  logic      read_n,
   input  logic      write_n,
   input  logic      den,
   output bsm_mode_e mode_q,
   output logic      drive_en
);

   bsm_mode_e mode_d;

   always_comb begin
      if (!den) mode_d = MODE_RECIRC;
      else      mode_d = bsm_mode_e'({~write_n, ~read_n});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_RECIRC;
         drive_en <= 1'b0;
      end else if (ph1) begin
         mode_q   <= mode_d;
         drive_en <= 1'b0;
      end else if (ph2) begin
         drive_en <= mode_reads(mode_q);
      end
   end

   // R8: phase one always releases the bus
   assert_release_on_ph1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ph1 |=> !drive_en);

   // R8: the drive only starts on a second-phase edge
   assert_drive_after_ph2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_en) |-> $past(ph2));

   // R6: a disabled device latches pure recirculation
   assert_disabled_recirc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph1 && !den) |=> (mode_q == MODE_RECIRC));

   // R7: the mode holds between first-phase pulses
   assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ph1 |=> $stable(mode_q));

endmodule

// File: rtl/bsm_pos_counter.sv
module bsm_pos_counter #(
   parameter int DEPTH = 1024
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ph2,
   output logic [$clog2(DEPTH)-1:0] pos
);

   localparam int POS_W = $clog2(DEPTH);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(DEPTH - 1);

   logic [POS_W-1:0] pos_next;

   generate
      if (DEPTH == (1 << POS_W)) begin : g_pow2
         assign pos_next = pos + 1'b1;
      end else begin : g_mod
         assign pos_next = (pos == POS_LAST) ? '0 : pos + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pos <= '0;
      else if (ph2) pos <= pos_next;
   end

   assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ph2 |=> $stable(pos));

   assert_pos_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph2 && pos == POS_LAST) |=> (pos == '0));

   assert_pos_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph2 && pos != POS_LAST) |=> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/bsm_segment.sv
module bsm_segment #(
   parameter int WORD_W  = 9,
   parameter int SEG_LEN = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ph1,
   input  logic              ph2,
   input  logic [WORD_W-1:0] seg_in,
   output logic [WORD_W-1:0] seg_out
);

   // delay line of SEG_LEN-1 words plus the refresh stage gives SEG_LEN bit cycles
   localparam int LINE_LEN = SEG_LEN - 1;
   localparam int PTR_W    = $clog2(LINE_LEN);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(LINE_LEN - 1);

   logic [WORD_W-1:0] line_mem [LINE_LEN];
   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  ptr_next;
   logic [WORD_W-1:0] half_q;

   generate
      if (LINE_LEN == (1 << PTR_W)) begin : g_pow2
         assign ptr_next = ptr + 1'b1;
      end else begin : g_mod
         assign ptr_next = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (ph2) line_mem[ptr] <= seg_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= '0;
         seg_out <= '0;
         ptr     <= '0;
      end else if (ph1) begin
         half_q  <= line_mem[ptr];
      end else if (ph2) begin
         seg_out <= half_q;
         ptr     <= ptr_next;
      end
   end

   // R9: the refresh stage moves only on the second phase
   assert_refresh_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ph2 |=> $stable(seg_out));

   // R1: the pointer never leaves the delay line
   assert_ptr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_LAST);

endmodule

// File: rtl/bsm_shift_memory.sv
module bsm_shift_memory
   import bsm_pkg::*;
#(
   parameter int WORD_W  = 9,
   parameter int DEPTH   = 1024,
   parameter int SEG_LEN = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ph1,
   input  logic                     ph2,
   input  logic                     read_n,
   input  logic                     write_n,
   input  logic                     den,
   inout  wire  [WORD_W-1:0]        data,
   output logic [$clog2(DEPTH)-1:0] pos
);

   localparam int NUM_SEG = DEPTH / SEG_LEN;

   generate
      if (DEPTH % SEG_LEN != 0) begin : g_bad_split
         $error("DEPTH must be a whole number of segments");
      end
      if (SEG_LEN < 3) begin : g_bad_seg
         $error("SEG_LEN must be at least 3");
      end
      if (WORD_W < 1) begin : g_bad_width
         $error("WORD_W must be positive");
      end
   endgenerate

   bsm_mode_e         mode_q;
   logic              drive_en;
   logic [WORD_W-1:0] sensed_q;
   logic [WORD_W-1:0] head_in;
   logic [WORD_W-1:0] link [NUM_SEG+1];
   logic [WORD_W-1:0] tail;

   bsm_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph1      (ph1),
      .ph2      (ph2),
      .read_n   (read_n),
      .write_n  (write_n),
      .den      (den),
      .mode_q   (mode_q),
      .drive_en (drive_en)
   );

   bsm_pos_counter #(.DEPTH(DEPTH)) u_pos (
      .clk   (clk),
      .rst_n (rst_n),
      .ph2   (ph2),
      .pos   (pos)
   );

   assign tail    = link[NUM_SEG];
   assign head_in = mode_writes(mode_q) ? data : tail;
   assign link[0] = head_in;

   generate
      for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
         bsm_segment #(.WORD_W(WORD_W), .SEG_LEN(SEG_LEN)) u_seg (
            .clk     (clk),
            .rst_n   (rst_n),
            .ph1     (ph1),
            .ph2     (ph2),
            .seg_in  (link[k]),
            .seg_out (link[k+1])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sensed_q <= '0;
      else if (ph2) sensed_q <= tail;
   end

   assign data = (drive_en && den) ? sensed_q : {WORD_W{1'bz}};

   // R8: the two phases never overlap
   assert_phase_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph1 && ph2));

   // R3: the sensed byte changes only on a second-phase pulse
   assert_sense_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ph2 |=> $stable(sensed_q));

endmodule

// File: tb/bsm_shift_memory_tb.sv
`timescale 1ns/1ps
module bsm_shift_memory_tb;

   localparam int DEPTH = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ph1 = 1'b0, ph2 = 1'b0;
   logic       read_n = 1'b1, write_n = 1'b1, den = 1'b0;
   logic [8:0] tb_drv = '0;
   logic       tb_oe = 1'b0;
   wire  [8:0] bus;
   logic [9:0] pos;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit run_mon = 0;

   logic [8:0] model [DEPTH];
   int         mpos = 0;

   always #4 clk = ~clk;

   assign bus = tb_oe ? tb_drv : 9'bz;

   bsm_shift_memory u_dut (
      .clk(clk), .rst_n(rst_n), .ph1(ph1), .ph2(ph2),
      .read_n(read_n), .write_n(write_n), .den(den),
      .data(bus), .pos(pos)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // R2 and R9: the position is compared with the model on every clock
   always @(negedge clk) begin
      if (run_mon && !done) check(pos == 10'(mpos), "R2", pos, mpos);
   end

   function automatic logic [8:0] pat(input int a);
      return 9'((a * 37 + 5) & 511);
   endfunction

   // one bit cycle, entered just after a falling edge
   task automatic bit_cycle(input logic rn, input logic wn, input logic dn,
                            input logic [8:0] wd, input bit swap, input string tag);
      logic lat_rd, lat_wr;
      logic [8:0] old;
      read_n = rn; write_n = wn; den = dn; ph1 = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ph1 = 1'b0;
      lat_rd = dn & ~rn;
      lat_wr = dn & ~wn;
      if (swap) begin read_n = ~rn; write_n = ~wn; end
      tb_drv = wd; tb_oe = 1'b1;
      #1 check(bus == wd, "R8", bus, wd);
      ph2 = 1'b1;
      @(posedge clk);
      #1;
      old = model[mpos];
      if (lat_wr) model[mpos] = wd;
      mpos = (mpos + 1) % DEPTH;
      @(negedge clk);
      ph2 = 1'b0; tb_oe = 1'b0;
      #1;
      if (lat_rd) begin
         check(bus == old, tag, bus, old);
      end else begin
         tb_drv = ~wd; tb_oe = 1'b1;
         #1 check(bus == ~wd, tag, bus, ~wd);
         tb_oe = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   task automatic read_pass(input string tag);
      for (int a = 0; a < DEPTH; a++) bit_cycle(1'b0, 1'b1, 1'b1, 9'h000, 1'b0, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R10: reset state
      check(pos == 10'd0, "R10", pos, 0);
      tb_drv = 9'h0A5; tb_oe = 1'b1;
      #1 check(bus == 9'h0A5, "R10", bus, 9'h0A5);
      tb_oe = 1'b0;
      run_mon = 1;
      idle(1);

      // R4: fill every position, with standby gaps (R9)
      for (int a = 0; a < DEPTH; a++) begin
         bit_cycle(1'b1, 1'b0, 1'b1, pat(a), 1'b0, "R4");
         if (a % 100 == 50) idle(3);
      end
      check(pos == 10'd0, "R2", pos, 0);

      // R3: read everything back
      read_pass("R3");

      // R5: read-modify-write over the whole store
      for (int a = 0; a < DEPTH; a++)
         bit_cycle(1'b0, 1'b0, 1'b1, pat(a) ^ 9'h155, 1'b0, "R5");

      // R1: full-period retention of the modified data
      idle(20);
      read_pass("R1");

      // R6: disabled device ignores both strobes
      for (int a = 0; a < DEPTH; a++)
         bit_cycle(1'b0, 1'b0, 1'b0, pat(a + 7), 1'b0, "R6");
      read_pass("R6");

      // R7: strobes swapped after the mode latch
      for (int a = 0; a < 64; a++)
         bit_cycle(1'b0, 1'b1, 1'b1, 9'h1FF, 1'b1, "R7");
      for (int a = 0; a < 64; a++)
         bit_cycle(1'b1, 1'b0, 1'b1, pat(a + 300), 1'b1, "R7");
      idle(5);
      read_pass("R7");
      check(pos == 10'(mpos), "R9", pos, mpos);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule